// File: doc/BRIEF.md
# Shadow-ROM Memory Map Controller

This block sits between a 16-bit CPU address bus and the memories of a small computer. It splits the 64K space into eight 8K blocks taken from the top three address bits. From those blocks it produces chip selects and write enables for the video-shared RAM, the I/O area, the system ROM, a fast shadow RAM that lies at the same addresses as the ROM, and an expansion block that holds one RAM bank and one EEPROM bank. It also drives enables for the three spare external blocks.

After reset the shadow RAM behind the ROM receives writes only, and the ROM answers reads. Firmware placed in the expansion block can therefore read the ROM and write the same addresses, which copies the ROM into the shadow RAM. It then sets a configuration bit that sends reads to the shadow RAM. A second bit write-protects all added memory in blocks 5 to 7. A third bit enables fast mode. An external switch forces slow mode whatever that bit holds.

Every access is classed as slow or fast. The slow indication lets the clock logic stretch the cycle. Accesses to the video block and the I/O block are always slow.

Top module: `shadow_map_ctrl`

## Requirements
- R1: Block n is address bits [15:13] == n. vid_cs_o is high only in block 0. ext_cs_o[k-1] is high only in block k, for k = 1, 2 and 3. io_cs_o is high in block 4 at every address except CFG_ADDR.
- R2: After reset all three stored configuration bits are 0: slow mode, ROM answers reads, no write protection.
- R3: While bit 1 is 0, a read in blocks 6 and 7 asserts rom_cs_o and not shadow_cs_o. A write there asserts shadow_cs_o and not rom_cs_o. rom_cs_o is never high on a write.
- R4: While configuration bit 1 (shadow read) is 1, a read in blocks 6 and 7 asserts shadow_cs_o, and rom_cs_o stays low.
- R5: While configuration bit 2 (write protect) is 1, shadow_we_o, xram_we_o and eeprom_we_o stay low on writes. The chip selects still follow the address. While bit 2 is 0, a write to a selected memory in these blocks asserts its write enable.
- R6: Block 5 is split by address bit 12. A 0 selects the RAM bank (xram_cs_o) and a 1 selects the EEPROM bank (eeprom_cs_o).
- R7: The configuration register loads wdata_i[2:0] on the clock edge of a cycle where access_i is 1, rnw_i is 0 and addr_i equals CFG_ADDR (default 16'h9FF0). Reads, writes to other addresses and cycles with access_i at 0 leave it unchanged.
- R8: rdata_o returns bit 0 fast enable, bit 1 shadow read, bit 2 write protect, bit 3 the live force_slow_i level, and zeros above.
- R9: slow_cycle_o is high when fast mode is off, or when the address is in block 0 or block 4. Otherwise fast_cycle_o is high. The two outputs are always complements.
- R10: force_slow_i high forces slow_cycle_o high in every block, even with the fast bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| access_i | input | 1 | Bus cycle valid, one clock per access |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | Write data |
| force_slow_i | input | 1 | External switch, 1 forces slow mode |
| rdata_o | output | 8 | Configuration readback |
| vid_cs_o | output | 1 | Video-shared RAM select (block 0) |
| ext_cs_o | output | 3 | External enables for blocks 1 to 3 |
| io_cs_o | output | 1 | I/O select (block 4, except the configuration address) |
| xram_cs_o | output | 1 | Expansion RAM bank select |
| xram_we_o | output | 1 | Expansion RAM write enable |
| eeprom_cs_o | output | 1 | Expansion EEPROM bank select |
| eeprom_we_o | output | 1 | Expansion EEPROM write enable |
| rom_cs_o | output | 1 | System ROM select (reads only) |
| shadow_cs_o | output | 1 | Shadow RAM select |
| shadow_we_o | output | 1 | Shadow RAM write enable |
| slow_cycle_o | output | 1 | Current access must run at the slow rate |
| fast_cycle_o | output | 1 | Current access may run fast |

## Verification
All chip selects, write enables, the slow/fast flags and rdata_o are combinational, so they are due in the same cycle as a change of address, R/W or switch. The bench drives inputs at the falling edge and samples one nanosecond later, before the next rising edge. A configuration write takes effect at the next rising edge. Its effect is checked after the following falling edge, which is one register stage later. The no-effect cases are checked through the readback of rdata_o.

// File: rtl/shadow_map_pkg.sv
package shadow_map_pkg;
  typedef struct packed {
    logic wp_en;
    logic shadow_rd;
    logic fast_en;
  } cfg_t;

  localparam int CFG_BITS = 3;
  localparam int SW_BIT   = 3;

  localparam int BLK_VID = 0;
  localparam int BLK_IO  = 4;
  localparam int BLK_EXP = 5;
  localparam int BLK_RLO = 6;
  localparam int BLK_RHI = 7;
endpackage

// File: rtl/smc_blk_decode.sv
module smc_blk_decode #(
  parameter int ADDR_W   = 16,
  parameter int BLK_BITS = 3,
  localparam int NUM_BLK = 1 << BLK_BITS
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_BLK-1:0] blk_oh_o,
  output logic               bank_hi_o
);
  localparam int BANK_BIT = ADDR_W - BLK_BITS - 1;

  logic [BLK_BITS-1:0] blk_idx;
  assign blk_idx   = addr_i[ADDR_W-1 -: BLK_BITS];
  assign bank_hi_o = addr_i[BANK_BIT];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    assign blk_oh_o[g] = (blk_idx == BLK_BITS'(g));
  end

  logic unused_addr;
  assign unused_addr = ^addr_i[BANK_BIT-1:0];
endmodule

// File: rtl/smc_cfg_reg.sv
module smc_cfg_reg
  import shadow_map_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h9FF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              access_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              force_slow_i,
  output logic              hit_o,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_en;

  assign hit_o = (addr_i == CFG_ADDR);
  assign wr_en = access_i && !rnw_i && hit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_o <= '0;
    else if (wr_en) cfg_o <= cfg_t'(wdata_i[CFG_BITS-1:0]);
  end

  assign rdata_o = DATA_W'({force_slow_i, cfg_o});

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:CFG_BITS];

  // R7: register loads on a qualified write, holds otherwise
  assert_cfg_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (cfg_o == cfg_t'($past(wdata_i[CFG_BITS-1:0]))));
  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(cfg_o));
endmodule

// File: rtl/smc_cycle_class.sv
module smc_cycle_class (
  input  logic force_slow_i,
  input  logic fast_en_i,
  input  logic slow_blk_i,
  output logic slow_o,
  output logic fast_o
);
  assign slow_o = force_slow_i || !fast_en_i || slow_blk_i;
  assign fast_o = !slow_o;
endmodule

// File: rtl/shadow_map_ctrl.sv
module shadow_map_ctrl
  import shadow_map_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h9FF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              access_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              force_slow_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              vid_cs_o,
  output logic [2:0]        ext_cs_o,
  output logic              io_cs_o,
  output logic              xram_cs_o,
  output logic              xram_we_o,
  output logic              eeprom_cs_o,
  output logic              eeprom_we_o,
  output logic              rom_cs_o,
  output logic              shadow_cs_o,
  output logic              shadow_we_o,
  output logic              slow_cycle_o,
  output logic              fast_cycle_o
);
  localparam int BLK_BITS = 3;
  localparam int NUM_BLK  = 1 << BLK_BITS;

  logic [NUM_BLK-1:0] blk_oh;
  logic               bank_hi;
  logic               cfg_hit;
  cfg_t               cfg;
  logic               rom_blk;
  logic               wr;

  smc_blk_decode #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_dec (
    .addr_i    (addr_i),
    .blk_oh_o  (blk_oh),
    .bank_hi_o (bank_hi)
  );

  smc_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .access_i     (access_i),
    .rnw_i        (rnw_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .force_slow_i (force_slow_i),
    .hit_o        (cfg_hit),
    .cfg_o        (cfg),
    .rdata_o      (rdata_o)
  );

  smc_cycle_class u_cls (
    .force_slow_i (force_slow_i),
    .fast_en_i    (cfg.fast_en),
    .slow_blk_i   (blk_oh[BLK_VID] || blk_oh[BLK_IO]),
    .slow_o       (slow_cycle_o),
    .fast_o       (fast_cycle_o)
  );

  assign wr      = !rnw_i;
  assign rom_blk = blk_oh[BLK_RLO] || blk_oh[BLK_RHI];

  assign vid_cs_o = blk_oh[BLK_VID];
  assign ext_cs_o = blk_oh[3:1];
  assign io_cs_o  = blk_oh[BLK_IO] && !cfg_hit;

  assign xram_cs_o   = blk_oh[BLK_EXP] && !bank_hi;
  assign eeprom_cs_o = blk_oh[BLK_EXP] &&  bank_hi;
  assign xram_we_o   = xram_cs_o   && wr && !cfg.wp_en;
  assign eeprom_we_o = eeprom_cs_o && wr && !cfg.wp_en;

  // ROM reads only; shadow RAM takes writes always, reads once switched over
  assign rom_cs_o    = rom_blk && rnw_i && !cfg.shadow_rd;
  assign shadow_cs_o = rom_blk && (wr || cfg.shadow_rd);
  assign shadow_we_o = shadow_cs_o && wr && !cfg.wp_en;

  assert_rom_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rnw_i |-> !rom_cs_o);
  assert_rom_off_shadow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.shadow_rd |-> !rom_cs_o);
  assert_wp_blocks_we_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.wp_en |-> !(shadow_we_o || xram_we_o || eeprom_we_o));
  assert_one_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_cs_o, shadow_cs_o, xram_cs_o, eeprom_cs_o, io_cs_o, vid_cs_o}));
  assert_slow_blk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_cs_o || io_cs_o) |-> slow_cycle_o);
  assert_force_slow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_slow_i |-> (slow_cycle_o && !fast_cycle_o));
endmodule

// File: tb/tb_shadow_map_ctrl.sv
module tb_shadow_map_ctrl;
  localparam logic [15:0] CFG = 16'h9FF0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        access_i = 1'b0;
  logic        rnw_i = 1'b1;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        force_slow_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        vid_cs_o, io_cs_o, xram_cs_o, xram_we_o, eeprom_cs_o, eeprom_we_o;
  logic        rom_cs_o, shadow_cs_o, shadow_we_o, slow_cycle_o, fast_cycle_o;
  logic [2:0]  ext_cs_o;

  int n_chk = 0;
  int n_bad = 0;

  shadow_map_ctrl dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic rd);
    @(negedge clk_i);
    access_i = 1'b0; addr_i = a; rnw_i = rd;
    #1;
  endtask

  task automatic cfg_wr(input logic [7:0] d);
    @(negedge clk_i);
    access_i = 1'b1; rnw_i = 1'b0; addr_i = CFG; wdata_i = d;
    @(negedge clk_i);
    access_i = 1'b0; rnw_i = 1'b1;
    #1;
  endtask

  task automatic t_reset;
    put(16'hC000, 1'b1);
    chk("R2 cfg", 32'(rdata_o), 32'h0);
    chk("R3 rom rd", 32'(rom_cs_o), 1);
    chk("R3 shadow rd", 32'(shadow_cs_o), 0);
    chk("R9 slow after reset", 32'({slow_cycle_o, fast_cycle_o}), 32'b10);
  endtask

  task automatic t_decode;
    for (int b = 0; b < 8; b++) begin
      put(16'(b << 13) | 16'h0123, 1'b1);
      chk("R1 vid", 32'(vid_cs_o), 32'(b == 0));
      chk("R1 ext", 32'(ext_cs_o), (b >= 1 && b <= 3) ? 32'(1 << (b - 1)) : 0);
      chk("R1 io", 32'(io_cs_o), 32'(b == 4));
    end
    put(CFG, 1'b1);
    chk("R1 io at cfg", 32'(io_cs_o), 0);
  endtask

  task automatic t_shadow_write;
    put(16'hE000, 1'b0);
    chk("R3 wr sel", 32'({rom_cs_o, shadow_cs_o, shadow_we_o}), 32'b011);
    put(16'hFFFF, 1'b1);
    chk("R3 rd sel", 32'({rom_cs_o, shadow_cs_o}), 32'b10);
  endtask

  task automatic t_bank_split;
    put(16'hA000, 1'b0);
    chk("R6 ram", 32'({xram_cs_o, xram_we_o, eeprom_cs_o}), 32'b110);
    put(16'hB800, 1'b0);
    chk("R6 eeprom", 32'({eeprom_cs_o, eeprom_we_o, xram_cs_o}), 32'b110);
  endtask

  task automatic t_ignore;
    @(negedge clk_i);
    access_i = 1'b0; rnw_i = 1'b0; addr_i = CFG; wdata_i = 8'h07;
    @(negedge clk_i); #1;
    chk("R7 no access", 32'(rdata_o), 0);
    access_i = 1'b1; addr_i = CFG + 16'd1;
    @(negedge clk_i); #1;
    chk("R7 other addr", 32'(rdata_o), 0);
    rnw_i = 1'b1; addr_i = CFG;
    @(negedge clk_i); #1;
    chk("R7 read", 32'(rdata_o), 0);
    access_i = 1'b0;
  endtask

  task automatic t_readback;
    cfg_wr(8'hFF);
    chk("R8 readback", 32'(rdata_o), 32'h07);
    force_slow_i = 1'b1; #1;
    chk("R8 switch bit", 32'(rdata_o), 32'h0F);
    force_slow_i = 1'b0;
    cfg_wr(8'h00);
    chk("R7 clear", 32'(rdata_o), 0);
  endtask

  task automatic t_shadow_read;
    cfg_wr(8'h02);
    put(16'hC010, 1'b1);
    chk("R4 rd", 32'({rom_cs_o, shadow_cs_o, shadow_we_o}), 32'b010);
    put(16'hE010, 1'b0);
    chk("R4 wr", 32'({rom_cs_o, shadow_cs_o, shadow_we_o}), 32'b011);
  endtask

  task automatic t_protect;
    cfg_wr(8'h06);
    put(16'hE000, 1'b0);
    chk("R5 shadow", 32'({shadow_cs_o, shadow_we_o}), 32'b10);
    put(16'hA100, 1'b0);
    chk("R5 xram", 32'({xram_cs_o, xram_we_o}), 32'b10);
    put(16'hB100, 1'b0);
    chk("R5 eeprom", 32'({eeprom_cs_o, eeprom_we_o}), 32'b10);
    cfg_wr(8'h02);
    put(16'hA100, 1'b0);
    chk("R5 unprot", 32'({xram_cs_o, xram_we_o}), 32'b11);
  endtask

  task automatic t_speed;
    cfg_wr(8'h01);
    put(16'h2000, 1'b1);
    chk("R9 fast blk1", 32'({slow_cycle_o, fast_cycle_o}), 32'b01);
    put(16'hE000, 1'b0);
    chk("R9 fast blk7", 32'({slow_cycle_o, fast_cycle_o}), 32'b01);
    put(16'h0400, 1'b1);
    chk("R9 blk0 slow", 32'({slow_cycle_o, fast_cycle_o}), 32'b10);
    put(16'h9000, 1'b1);
    chk("R9 blk4 slow", 32'({slow_cycle_o, fast_cycle_o}), 32'b10);
    put(16'h2000, 1'b1);
    force_slow_i = 1'b1; #1;
    chk("R10 forced", 32'({slow_cycle_o, fast_cycle_o}), 32'b10);
    put(16'hC000, 1'b1);
    chk("R10 forced rom", 32'({slow_cycle_o, fast_cycle_o}), 32'b10);
    force_slow_i = 1'b0; #1;
    chk("R10 released", 32'({slow_cycle_o, fast_cycle_o}), 32'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_decode();
    t_shadow_write();
    t_bank_split();
    t_ignore();
    t_readback();
    t_shadow_read();
    t_protect();
    t_speed();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule